// File: doc/BRIEF.md
# Product-Term Plane with Fixed Grouping

This block is the programmable AND plane of a small sum-of-products logic element. Twenty logic signals enter it: ten general data pins, a clock pin, an output-enable pin and eight feedback lines returned from the output cells. Each signal is buffered into a true column and a complement column, giving forty columns. A stored connection map selects, for each of 64 product terms, which columns take part in that term. The term is the AND of its selected columns. Terms are numbered so that terms 8c to 8c+7 form the group that feeds output cell c.

The connection map is written one term row at a time through a word-wide port, and it clears to the unprogrammed state on reset. A mode input says whether the device uses registers. When it does, the clock and output-enable pins are taken away from the array. Both of their columns then read HIGH, so any connection to them has no effect. The path from signals to terms has no register, so a change on a pin shows on the terms without a clock edge.

Top module: `pla_and_plane`

## Requirements
- R1: While rst_n is low, every stored connection is cleared (asynchronous). All 64 bits of pt_out are then HIGH, whatever the pins carry.
- R2: A term whose stored row has no bit set drives HIGH for every input pattern.
- R3: A term that connects both the true and the complement column of the same active signal drives LOW.
- R4: Term t is the AND of the columns selected in row t. Row bit 2k connects the true column of signal k, and bit 2k+1 connects its complement. Signal numbers: 0 to 9 are dat_pins[0..9], 10 is clk_pin, 11 is oe_pin, 12 to 19 are fb_in[0..7].
- R5: When regd_mode is 1, both columns of clk_pin and of oe_pin read HIGH. Terms then ignore those pins, and a term that connects both polarities of one of them is not forced LOW.
- R6: When regd_mode is 0, clk_pin and oe_pin drive their column pairs in the same way as any data pin.
- R7: A rising clk edge with cfg_we high replaces row cfg_row with cfg_data. From that edge onward the new row sets pt_out, and the other rows keep their contents.
- R8: With cfg_we low, a clock edge leaves the connection map unchanged, whatever cfg_row and cfg_data carry.
- R9: pt_out follows changes on the pins, the feedback lines and regd_mode within the same clock cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for map writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears the map |
| regd_mode | input | 1 | 1: device uses registers, clock and enable pins leave the array |
| dat_pins | input | 10 | General data pins, signals 0..9 |
| clk_pin | input | 1 | Clock pin as a candidate array signal (10) |
| oe_pin | input | 1 | Output-enable pin as a candidate array signal (11) |
| fb_in | input | 8 | Feedback from output cells, signals 12..19 |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row (term) index to write |
| cfg_data | input | 40 | New connection row, bit 2k true, 2k+1 complement |
| pt_out | output | 64 | Product-term values; term 8c+j belongs to cell c |

## Verification
The hardest case to reach from the ports is a term that connects both polarities of the clock or enable pin. That term must read LOW in one mode and ignore the pin in the other, and it has to be seen flipping only because regd_mode changes. The bench programs such a row and applies the same pin pattern in both modes. It compares all 64 terms against a loop-based model that skips inactive signals. The bench also checks that a held-off write and a reset both show at pt_out. It programs rows whose level would change if a stray write landed, and rows that keep the outputs LOW until a reset clears them.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned DEF_NDAT = 10;
  localparam int unsigned DEF_NFB  = 8;
  localparam int unsigned DEF_NPT  = 64;
  localparam int unsigned DEF_GRP  = 8;

  // Column pair for one signal: bit0 true, bit1 complement.
  // An inactive signal reads HIGH on both so a connection is neutral.
  function automatic logic [1:0] col_pair(input logic val, input logic active);
    col_pair = active ? {~val, val} : 2'b11;
  endfunction
endpackage

// File: rtl/pla_col_buf.sv
module pla_col_buf #(
  parameter int unsigned NDAT = 10,
  parameter int unsigned NFB  = 8,
  localparam int unsigned NSIG = NDAT + NFB + 2,
  localparam int unsigned NCOL = 2 * NSIG
) (
  input  logic            regd_mode,
  input  logic [NDAT-1:0] dat_pins,
  input  logic            clk_pin,
  input  logic            oe_pin,
  input  logic [NFB-1:0]  fb_in,
  output logic [NCOL-1:0] cols,
  output logic [NSIG-1:0] act_mask
);
  import pla_pkg::*;

  for (genvar k = 0; k < NSIG; k++) begin : g_sig
    logic v;
    logic a;
    if (k < NDAT) begin : g_dat
      assign v = dat_pins[k];
      assign a = 1'b1;
    end else if (k == NDAT) begin : g_ck
      assign v = clk_pin;
      assign a = ~regd_mode;
    end else if (k == NDAT + 1) begin : g_oe
      assign v = oe_pin;
      assign a = ~regd_mode;
    end else begin : g_fb
      assign v = fb_in[k-NDAT-2];
      assign a = 1'b1;
    end
    assign cols[2*k+1:2*k] = col_pair(v, a);
    assign act_mask[k]     = a;
  end
endmodule

// File: rtl/pla_conn_map.sv
module pla_conn_map #(
  parameter int unsigned NCOL = 40,
  parameter int unsigned NPT  = 64,
  localparam int unsigned RW  = $clog2(NPT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [RW-1:0]             addr,
  input  logic [NCOL-1:0]           wdata,
  output logic [NPT-1:0][NCOL-1:0]  map_q
);
  for (genvar r = 0; r < NPT; r++) begin : g_row
    logic hit;
    assign hit = we && (addr == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map_q[r] <= '0;
      else if (hit) map_q[r] <= wdata;
    end
  end
endmodule

// File: rtl/pla_term.sv
module pla_term #(
  parameter int unsigned NCOL = 40
) (
  input  logic [NCOL-1:0] row,
  input  logic [NCOL-1:0] cols,
  output logic            pt
);
  // Every selected column must be HIGH; unselected ones are don't-care.
  function automatic logic and_selected(input logic [NCOL-1:0] r, input logic [NCOL-1:0] c);
    and_selected = &(c | ~r);
  endfunction

  assign pt = and_selected(row, cols);
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned NDAT = pla_pkg::DEF_NDAT,
  parameter int unsigned NFB  = pla_pkg::DEF_NFB,
  parameter int unsigned NPT  = pla_pkg::DEF_NPT,
  parameter int unsigned GRP  = pla_pkg::DEF_GRP,
  localparam int unsigned NSIG = NDAT + NFB + 2,
  localparam int unsigned NCOL = 2 * NSIG,
  localparam int unsigned RW   = $clog2(NPT),
  localparam int unsigned NCELL = NPT / GRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regd_mode,
  input  logic [NDAT-1:0] dat_pins,
  input  logic            clk_pin,
  input  logic            oe_pin,
  input  logic [NFB-1:0]  fb_in,
  input  logic            cfg_we,
  input  logic [RW-1:0]   cfg_row,
  input  logic [NCOL-1:0] cfg_data,
  output logic [NPT-1:0]  pt_out
);
  logic [NCOL-1:0]          cols;
  logic [NSIG-1:0]          act_mask;
  logic [NPT-1:0][NCOL-1:0] map_q;
  logic [NPT-1:0]           row_empty;
  logic [NPT-1:0]           row_conflict;

  // Row holds a true/complement pair on any signal that is currently active.
  function automatic logic has_conflict(input logic [NCOL-1:0] r, input logic [NSIG-1:0] m);
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < NSIG; k++) acc |= r[2*k] & r[2*k+1] & m[k];
    return acc;
  endfunction

  pla_col_buf #(.NDAT(NDAT), .NFB(NFB)) u_cols (
    .regd_mode(regd_mode), .dat_pins(dat_pins), .clk_pin(clk_pin),
    .oe_pin(oe_pin), .fb_in(fb_in), .cols(cols), .act_mask(act_mask)
  );

  pla_conn_map #(.NCOL(NCOL), .NPT(NPT)) u_map (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_row),
    .wdata(cfg_data), .map_q(map_q)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    for (genvar j = 0; j < GRP; j++) begin : g_pt
      localparam int unsigned T = c * GRP + j;
      pla_term #(.NCOL(NCOL)) u_term (
        .row(map_q[T]), .cols(cols), .pt(pt_out[T])
      );
      assign row_empty[T]    = ~|map_q[T];
      assign row_conflict[T] = has_conflict(map_q[T], act_mask);
    end
  end
endmodule

// File: rtl/pla_and_plane_chk.sv
module pla_and_plane_chk #(
  parameter int unsigned NDAT = 10,
  parameter int unsigned NCOL = 40,
  parameter int unsigned NPT  = 64,
  parameter int unsigned RW   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     regd_mode,
  input logic                     clk_pin,
  input logic                     oe_pin,
  input logic                     cfg_we,
  input logic [RW-1:0]            cfg_row,
  input logic [NCOL-1:0]          cfg_data,
  input logic [NPT-1:0][NCOL-1:0] map_q,
  input logic [NCOL-1:0]          cols,
  input logic [NPT-1:0]           pt_out,
  input logic [NPT-1:0]           row_empty,
  input logic [NPT-1:0]           row_conflict
);
  localparam int unsigned CK = 2 * NDAT;
  localparam int unsigned OE = 2 * NDAT + 2;

  a_r2_empty_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_out & row_empty) == row_empty);

  a_r3_conflict_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_out & row_conflict) == '0);

  a_r5_regd_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    regd_mode |-> (cols[CK+1:CK] == 2'b11 && cols[OE+1:OE] == 2'b11));

  a_r6_comb_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !regd_mode |-> (cols[CK] == clk_pin && cols[CK+1] == !clk_pin &&
                    cols[OE] == oe_pin && cols[OE+1] == !oe_pin));

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (map_q[$past(cfg_row)] == $past(cfg_data)));

  a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(map_q));
endmodule

bind pla_and_plane pla_and_plane_chk #(
  .NDAT(NDAT), .NCOL(NCOL), .NPT(NPT), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regd_mode(regd_mode), .clk_pin(clk_pin),
  .oe_pin(oe_pin), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
  .map_q(map_q), .cols(cols), .pt_out(pt_out), .row_empty(row_empty),
  .row_conflict(row_conflict)
);

// File: tb/pla_and_plane_bench.sv
`timescale 1ns/1ps
module pla_and_plane_bench;
  localparam int NPT = 64;
  localparam int NCOL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regd_mode = 1'b0;
  logic [9:0]  dat_pins = '0;
  logic        clk_pin = 1'b0;
  logic        oe_pin = 1'b0;
  logic [7:0]  fb_in = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_row = '0;
  logic [39:0] cfg_data = '0;
  logic [63:0] pt_out;

  logic [39:0] ref_map [NPT];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pla_and_plane u_pla_and_plane (
    .clk(clk), .rst_n(rst_n), .regd_mode(regd_mode), .dat_pins(dat_pins),
    .clk_pin(clk_pin), .oe_pin(oe_pin), .fb_in(fb_in), .cfg_we(cfg_we),
    .cfg_row(cfg_row), .cfg_data(cfg_data), .pt_out(pt_out)
  );

  function automatic logic [39:0] tc(int k); return 40'b1 << (2*k); endfunction
  function automatic logic [39:0] cc(int k); return 40'b1 << (2*k+1); endfunction

  function automatic logic sig_val(int k);
    if (k < 10) return dat_pins[k];
    if (k == 10) return clk_pin;
    if (k == 11) return oe_pin;
    return fb_in[k-12];
  endfunction

  // Reference: a term fails if any connected, active literal is false.
  function automatic logic [63:0] model();
    logic [63:0] r;
    for (int t = 0; t < NPT; t++) begin
      r[t] = 1'b1;
      for (int k = 0; k < 20; k++) begin
        if (regd_mode && (k == 10 || k == 11)) continue;
        if (ref_map[t][2*k]   && !sig_val(k)) r[t] = 1'b0;
        if (ref_map[t][2*k+1] &&  sig_val(k)) r[t] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] exp);
    n_chk++;
    if (pt_out !== exp) begin
      n_bad++;
      $display("FAIL %s: pt_out=%h expected=%h", req, pt_out, exp);
    end
  endtask

  task automatic wr(int row, logic [39:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 6'(row); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    ref_map[row] = d;
  endtask

  // {regd_mode, fb_in[7:0], oe_pin, clk_pin, dat_pins[9:0]}
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 10'h000},
    {1'b0, 8'hF7, 1'b1, 1'b1, 10'h3FF},
    {1'b0, 8'hFF, 1'b1, 1'b1, 10'h3FF},
    {1'b0, 8'h80, 1'b0, 1'b1, 10'h007},
    {1'b0, 8'h00, 1'b0, 1'b0, 10'h006},
    {1'b0, 8'h08, 1'b1, 1'b0, 10'h001},
    {1'b1, 8'hFF, 1'b1, 1'b1, 10'h3FF},
    {1'b1, 8'hFF, 1'b0, 1'b0, 10'h3FF},
    {1'b1, 8'h00, 1'b0, 1'b0, 10'h001},
    {1'b1, 8'h80, 1'b1, 1'b0, 10'h006},
    {1'b0, 8'h55, 1'b0, 1'b1, 10'h2AA},
    {1'b1, 8'hAA, 1'b1, 1'b0, 10'h155}
  };

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: pt_out=%h expected=finished run", pt_out);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NPT; t++) ref_map[t] = '0;
    dat_pins = 10'h155; fb_in = 8'h3C; clk_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset clears map", {64{1'b1}});
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 unprogrammed terms high", {64{1'b1}});

    wr(1,  tc(0) | cc(15));
    wr(2,  tc(4) | cc(4));
    wr(3,  tc(10));
    wr(4,  cc(10) | cc(11));
    wr(9,  40'h55_5555_5555);
    wr(20, tc(10) | cc(10));
    wr(33, tc(1) | tc(2) | cc(3) | tc(11));
    wr(63, tc(19));
    check("R7 rows take effect after write", model());

    // Table walk: R4 selection, R3 conflicts, R5/R6 mode, R9 no clock needed
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {regd_mode, fb_in, oe_pin, clk_pin, dat_pins} = VEC[i];
      #1;
      check(VEC[i][20] ? "R5 R4 R3 regd vector" : "R6 R4 R3 comb vector", model());
    end

    // R5 vs R6: clk both-polarity row flips with mode only (R9 no edge)
    @(negedge clk);
    regd_mode = 1'b0; clk_pin = 1'b1; dat_pins = '0; fb_in = '0; oe_pin = 1'b0;
    #1;
    check("R6 clk conflict low in comb mode", model());
    regd_mode = 1'b1;
    #1;
    check("R5 clk conflict neutral in regd mode", model());

    // R8: strobe low, stray row/data present
    @(negedge clk);
    regd_mode = 1'b0; dat_pins = '0; fb_in = '0;
    cfg_we = 1'b0; cfg_row = 6'd1; cfg_data = '0;
    repeat (2) @(negedge clk);
    check("R8 no write without strobe", model());

    // R7: rewrite row 1 to empty, neighbours untouched
    wr(1, '0);
    check("R7 rewrite row to empty", model());

    // R1: reset after programming clears everything
    @(negedge clk);
    dat_pins = '0; fb_in = '0;
    rst_n = 1'b0;
    #1;
    check("R1 reset after programming", {64{1'b1}});
    for (int t = 0; t < NPT; t++) ref_map[t] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 all terms high after reset", model());

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule